// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Processor

This block is a small in-order processor with five stages: fetch, decode, execute, memory access and writeback. It runs a 32-bit integer instruction subset with the usual field layout: a 6-bit opcode in bits 31:26, source registers in 25:21 and 20:16, a destination in 15:11 and a function code in 5:0 for register-register forms, and a 16-bit immediate in 15:0 for immediate forms. The subset is add, subtract, and, or, signed set-less-than, a multiply that keeps the low word, add-immediate, set-less-than-immediate, word load, word store and branch-if-equal. The instruction and data memories are word arrays inside the block. A 32-entry register file sits between decode and writeback.

The pipeline detects no hazards and forwards nothing. Software keeps dependent instructions at least three slots apart and fills the three slots after every branch with useful work or NOPs, because those slots always execute. The instruction memory is filled through a program-load port while reset is held. After a run, the register file and the data memory are read back through two combinational observation ports.

Top module: `pcpu_core`

## Requirements
- R1: `rst` is synchronous and active high. After a reset edge, `fetch_pc` is 0, every general register reads 0 and every stage register holds an instruction with no architectural effect.
- R2: Register-register ADD (funct 0x20), SUB (0x22), AND (0x24) and OR (0x25) under opcode 0 write `rd` with the 32-bit result, wrapping on overflow.
- R3: MULT (opcode 0, funct 0x18) writes `rd` with the low 32 bits of the product of `rs` and `rt`.
- R4: SLT (opcode 0, funct 0x2A) and SLTI (opcode 0x0A) write 1 when the first operand is less than the second as signed two's-complement numbers, and 0 otherwise.
- R5: ADDI (opcode 0x08) and SLTI sign-extend their 16-bit immediate to 32 bits.
- R6: SW (opcode 0x2B) stores `rt` at byte address `rs` + sign-extended offset, and the word index is that address shifted right by 2. LW (opcode 0x23) from the same address returns the stored word into `rt`.
- R7: BEQ (opcode 0x04) compares `rs` and `rt`. When they are equal, fetch continues at branch PC + 4 + (sign-extended offset << 2). The three instructions fetched after the branch always complete. A branch that is not taken falls through, and a negative offset branches backward.
- R8: Register 0 always reads as zero, and a write that targets it has no effect.
- R9: There is no forwarding. An instruction one or two slots after a writer reads the old value of the register. An instruction three slots after the writer reads the new value, through the register file's same-cycle write pass-through.
- R10: Outside reset and without a taken branch, the PC advances by 4 each cycle. The fetched word is instruction memory entry `pc >> 2`, and that entry is written through the program-load port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Write enable for an instruction memory word |
| prog_addr | input | IAW | Word index of the instruction memory entry to write |
| prog_data | input | 32 | Instruction word to write |
| fetch_pc | output | 32 | Current fetch address |
| dbg_reg_sel | input | 5 | Register to observe |
| dbg_reg_val | output | 32 | Value of the observed register |
| dbg_mem_sel | input | DAW | Data memory word to observe |
| dbg_mem_val | output | 32 | Value of the observed data word |

## Verification
The assertions check on every cycle that fetch steps by four or jumps to the target of a taken branch, that the PC is zero after a reset edge, that register 0 reads as zero at decode, and that a decode read of the register being written back returns the writeback value. Only the bench's program can show the instruction results: arithmetic wrap, signed comparison, product truncation, immediate sign extension and the store-to-load round trip. The same holds for the old values seen by readers one or two slots behind a writer, for the branch shadow that always executes, and for an instruction skipped by a taken branch.

// File: rtl/pcpu_pkg.sv
package pcpu_pkg;

    localparam int XLEN = 32;
    localparam int RIDX = 5;

    typedef logic [XLEN-1:0] word_t;
    typedef logic [RIDX-1:0] ridx_t;

    localparam logic [5:0] OPC_REG  = 6'h00;
    localparam logic [5:0] OPC_BEQ  = 6'h04;
    localparam logic [5:0] OPC_ADDI = 6'h08;
    localparam logic [5:0] OPC_SLTI = 6'h0A;
    localparam logic [5:0] OPC_LW   = 6'h23;
    localparam logic [5:0] OPC_SW   = 6'h2B;

    localparam logic [5:0] FN_MUL = 6'h18;
    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT, ALU_MUL
    } alu_op_e;

    typedef struct packed {
        logic    reg_we;
        logic    mem_to_reg;
        logic    mem_we;
        logic    branch;
        logic    use_imm;
        alu_op_e alu_op;
    } ctrl_t;

    typedef struct packed {
        word_t pc4;
        word_t instr;
    } ifid_t;

    typedef struct packed {
        ctrl_t ctrl;
        word_t pc4;
        word_t rs_val;
        word_t rt_val;
        word_t imm;
        ridx_t dest;
    } idex_t;

    typedef struct packed {
        ctrl_t ctrl;
        word_t br_target;
        logic  equal;
        word_t alu_res;
        word_t store_val;
        ridx_t dest;
    } exmem_t;

    typedef struct packed {
        logic  reg_we;
        logic  mem_to_reg;
        word_t alu_res;
        word_t load_val;
        ridx_t dest;
    } memwb_t;

    function automatic word_t sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic ctrl_t decode(input word_t instr);
        ctrl_t c;
        c = '0;
        unique case (instr[31:26])
            OPC_REG: begin
                c.reg_we = 1'b1;
                case (instr[5:0])
                    FN_ADD:  c.alu_op = ALU_ADD;
                    FN_SUB:  c.alu_op = ALU_SUB;
                    FN_AND:  c.alu_op = ALU_AND;
                    FN_OR:   c.alu_op = ALU_OR;
                    FN_SLT:  c.alu_op = ALU_SLT;
                    FN_MUL:  c.alu_op = ALU_MUL;
                    default: c.reg_we = 1'b0;
                endcase
            end
            OPC_ADDI: begin c.reg_we = 1'b1; c.use_imm = 1'b1; c.alu_op = ALU_ADD; end
            OPC_SLTI: begin c.reg_we = 1'b1; c.use_imm = 1'b1; c.alu_op = ALU_SLT; end
            OPC_LW: begin
                c.reg_we = 1'b1; c.mem_to_reg = 1'b1; c.use_imm = 1'b1; c.alu_op = ALU_ADD;
            end
            OPC_SW:  begin c.mem_we = 1'b1; c.use_imm = 1'b1; c.alu_op = ALU_ADD; end
            OPC_BEQ: begin c.branch = 1'b1; c.alu_op = ALU_SUB; end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pcpu_stage_reg.sv
module pcpu_stage_reg #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // A cleared stage carries all-zero control, which acts as a NOP.
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/pcpu_regfile.sv
module pcpu_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] dbg_a,
    output logic [W-1:0]  dbg_d
);
    logic [W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    // Same-cycle write is passed through to the readers.
    function automatic logic [W-1:0] rd_port(input logic [AW-1:0] a);
        if (a == '0)             return '0;
        else if (we && wa == a)  return wd;
        else                     return regs[a];
    endfunction

    assign rd_a  = rd_port(ra_a);
    assign rd_b  = rd_port(ra_b);
    assign dbg_d = (dbg_a == '0) ? '0 : regs[dbg_a];
endmodule

// File: rtl/pcpu_alu.sv
module pcpu_alu
    import pcpu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         eq
);
    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_MUL: y = a * b;
            default: y = '0;
        endcase
    end
    assign eq = (a == b);
endmodule

// File: rtl/pcpu_core.sv
module pcpu_core
    import pcpu_pkg::*;
#(
    parameter int  IMEM_WORDS = 64,
    parameter int  DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            prog_we,
    input  logic [IAW-1:0]  prog_addr,
    input  logic [31:0]     prog_data,
    output logic [31:0]     fetch_pc,
    input  logic [4:0]      dbg_reg_sel,
    output logic [31:0]     dbg_reg_val,
    input  logic [DAW-1:0]  dbg_mem_sel,
    output logic [31:0]     dbg_mem_val
);
    // ---------------- fetch ----------------
    word_t  pc_q;
    word_t  imem [IMEM_WORDS];
    ifid_t  ifid_d, ifid_q;
    logic   br_taken;
    word_t  br_target;

    always_ff @(posedge clk) begin
        if (prog_we) imem[prog_addr] <= prog_data;
    end

    always_ff @(posedge clk) begin
        if (rst)           pc_q <= '0;
        else if (br_taken) pc_q <= br_target;
        else               pc_q <= pc_q + 32'd4;
    end

    assign fetch_pc     = pc_q;
    assign ifid_d.pc4   = pc_q + 32'd4;
    assign ifid_d.instr = imem[pc_q[IAW+1:2]];

    pcpu_stage_reg #(.WIDTH($bits(ifid_t))) ifid_r (
        .clk(clk), .rst(rst), .d(ifid_d), .q(ifid_q));

    // ---------------- decode ----------------
    ridx_t  id_rs, id_rt;
    word_t  id_rs_val, id_rt_val;
    idex_t  idex_d, idex_q;
    logic   wb_we;
    ridx_t  wb_dest;
    word_t  wb_data;

    assign id_rs = ifid_q.instr[25:21];
    assign id_rt = ifid_q.instr[20:16];

    pcpu_regfile #(.NREG(32), .W(XLEN)) rf_i (
        .clk(clk), .rst(rst),
        .ra_a(id_rs), .ra_b(id_rt), .rd_a(id_rs_val), .rd_b(id_rt_val),
        .we(wb_we), .wa(wb_dest), .wd(wb_data),
        .dbg_a(dbg_reg_sel), .dbg_d(dbg_reg_val));

    assign idex_d.ctrl   = decode(ifid_q.instr);
    assign idex_d.pc4    = ifid_q.pc4;
    assign idex_d.rs_val = id_rs_val;
    assign idex_d.rt_val = id_rt_val;
    assign idex_d.imm    = sext16(ifid_q.instr[15:0]);
    assign idex_d.dest   = (ifid_q.instr[31:26] == OPC_REG) ? ifid_q.instr[15:11] : id_rt;

    pcpu_stage_reg #(.WIDTH($bits(idex_t))) idex_r (
        .clk(clk), .rst(rst), .d(idex_d), .q(idex_q));

    // ---------------- execute ----------------
    word_t  ex_b, ex_y;
    logic   ex_eq;
    exmem_t exmem_d, exmem_q;

    assign ex_b = idex_q.ctrl.use_imm ? idex_q.imm : idex_q.rt_val;

    pcpu_alu #(.W(XLEN)) alu_i (
        .op(idex_q.ctrl.alu_op), .a(idex_q.rs_val), .b(ex_b), .y(ex_y), .eq(ex_eq));

    assign exmem_d.ctrl      = idex_q.ctrl;
    assign exmem_d.br_target = idex_q.pc4 + {idex_q.imm[XLEN-3:0], 2'b00};
    assign exmem_d.equal     = ex_eq;
    assign exmem_d.alu_res   = ex_y;
    assign exmem_d.store_val = idex_q.rt_val;
    assign exmem_d.dest      = idex_q.dest;

    pcpu_stage_reg #(.WIDTH($bits(exmem_t))) exmem_r (
        .clk(clk), .rst(rst), .d(exmem_d), .q(exmem_q));

    // ---------------- memory ----------------
    word_t  dmem [DMEM_WORDS];
    logic [DAW-1:0] mem_idx;
    memwb_t memwb_d, memwb_q;

    assign mem_idx   = exmem_q.alu_res[DAW+1:2];
    assign br_taken  = exmem_q.ctrl.branch & exmem_q.equal;
    assign br_target = exmem_q.br_target;

    always_ff @(posedge clk) begin
        if (exmem_q.ctrl.mem_we) dmem[mem_idx] <= exmem_q.store_val;
    end

    assign dbg_mem_val = dmem[dbg_mem_sel];

    assign memwb_d.reg_we     = exmem_q.ctrl.reg_we;
    assign memwb_d.mem_to_reg = exmem_q.ctrl.mem_to_reg;
    assign memwb_d.alu_res    = exmem_q.alu_res;
    assign memwb_d.load_val   = dmem[mem_idx];
    assign memwb_d.dest       = exmem_q.dest;

    pcpu_stage_reg #(.WIDTH($bits(memwb_t))) memwb_r (
        .clk(clk), .rst(rst), .d(memwb_d), .q(memwb_q));

    // ---------------- writeback ----------------
    assign wb_we   = memwb_q.reg_we;
    assign wb_dest = memwb_q.dest;
    assign wb_data = memwb_q.mem_to_reg ? memwb_q.load_val : memwb_q.alu_res;

endmodule

// File: rtl/pcpu_core_chk.sv
module pcpu_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] fetch_pc,
    input logic        br_taken,
    input logic [31:0] br_target,
    input logic [4:0]  id_rs,
    input logic [31:0] id_rs_val,
    input logic        wb_we,
    input logic [4:0]  wb_dest,
    input logic [31:0] wb_data
);
    logic rst_prev_q;

    always_ff @(posedge clk) begin
        rst_prev_q <= rst;
        // R1
        if (rst_prev_q) pc_reset_chk: assert (fetch_pc == 32'd0)
            else $error("pc not zero after reset edge");
    end

    // R10
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        !br_taken |=> fetch_pc == $past(fetch_pc) + 32'd4);

    // R7
    br_jump_chk: assert property (@(posedge clk) disable iff (rst)
        br_taken |=> fetch_pc == $past(br_target));

    // R8
    zero_read_chk: assert property (@(posedge clk) disable iff (rst)
        id_rs == 5'd0 |-> id_rs_val == 32'd0);

    // R9
    wb_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_we && wb_dest == id_rs && id_rs != 5'd0) |-> id_rs_val == wb_data);
endmodule

bind pcpu_core pcpu_core_chk chk_i (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc),
    .br_taken(br_taken), .br_target(br_target),
    .id_rs(id_rs), .id_rs_val(id_rs_val),
    .wb_we(wb_we), .wb_dest(wb_dest), .wb_data(wb_data));

// File: tb/pcpu_core_tb.sv
`timescale 1ns/1ps
module pcpu_core_tb_top;
    localparam int IAW = 6;
    localparam int DAW = 6;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           prog_we = 1'b0;
    logic [IAW-1:0] prog_addr = '0;
    logic [31:0]    prog_data = '0;
    logic [31:0]    fetch_pc;
    logic [4:0]     dbg_reg_sel = '0;
    logic [31:0]    dbg_reg_val;
    logic [DAW-1:0] dbg_mem_sel = '0;
    logic [31:0]    dbg_mem_val;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int slot   = 0;

    always #4 clk = ~clk;   // 125 MHz

    pcpu_core dut_i (
        .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_data(prog_data), .fetch_pc(fetch_pc),
        .dbg_reg_sel(dbg_reg_sel), .dbg_reg_val(dbg_reg_val),
        .dbg_mem_sel(dbg_mem_sel), .dbg_mem_val(dbg_mem_val));

    // Expected register file after the program: {register, value, requirement}
    localparam logic [40:0] EXP [28] = '{
        {5'd1,  32'h00000003, 4'd5},  // R5 addi
        {5'd2,  32'h00000004, 4'd5},  // R5
        {5'd3,  32'hFFFFFFFB, 4'd5},  // R5 negative immediate
        {5'd4,  32'h00000007, 4'd2},  // R2 add
        {5'd5,  32'hFFFFFFFF, 4'd2},  // R2 sub wraps
        {5'd6,  32'h00000003, 4'd2},  // R2 and
        {5'd7,  32'hFFFFFFFF, 4'd2},  // R2 or
        {5'd8,  32'h00000001, 4'd4},  // R4 slt -5 < 3
        {5'd9,  32'h00000000, 4'd4},  // R4 slt 3 < -5
        {5'd10, 32'h00000001, 4'd4},  // R4 slti -5 < -4
        {5'd11, 32'h00000000, 4'd4},  // R4 slti 3 < 2
        {5'd12, 32'hFFFFFFF1, 4'd3},  // R3 mult signed low word
        {5'd13, 32'h00007FFF, 4'd5},  // R5
        {5'd14, 32'h3FFF0001, 4'd3},  // R3
        {5'd15, 32'h40017FFF, 4'd3},  // R3 truncated product
        {5'd16, 32'h00000003, 4'd6},  // R6 load back
        {5'd17, 32'hFFFFFFFB, 4'd6},  // R6 base+offset load
        {5'd0,  32'h00000000, 4'd8},  // R8 write to zero ignored
        {5'd18, 32'h00000003, 4'd8},  // R8 zero as operand
        {5'd19, 32'h00000009, 4'd9},  // R9 writer
        {5'd20, 32'h00000000, 4'd9},  // R9 one slot behind: old
        {5'd21, 32'h00000000, 4'd9},  // R9 two slots behind: old
        {5'd22, 32'h00000009, 4'd9},  // R9 three slots behind: new
        {5'd23, 32'h00000001, 4'd7},  // R7 not-taken fallthrough
        {5'd24, 32'h0000000B, 4'd7},  // R7 shadow of not-taken
        {5'd25, 32'h00000015, 4'd7},  // R7 shadow of taken executes
        {5'd26, 32'h00000000, 4'd7},  // R7 skipped by taken branch
        {5'd27, 32'h00000037, 4'd7}   // R7 branch target
    };

    function automatic logic [31:0] rop(input int rd, input int rs, input int rt,
                                        input logic [5:0] fn);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction

    function automatic logic [31:0] iop(input logic [5:0] op, input int rt, input int rs,
                                        input logic [15:0] imm);
        return {op, rs[4:0], rt[4:0], imm};
    endfunction

    task automatic put(input logic [31:0] w);
        prog_addr = slot[IAW-1:0];
        prog_data = w;
        prog_we   = 1'b1;
        @(negedge clk);
        prog_we   = 1'b0;
        slot++;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_chk(input string req, input int r, input logic [31:0] exp);
        dbg_reg_sel = r[4:0];
        #1;
        chk(req, dbg_reg_val, exp);
    endtask

    initial begin
        @(negedge clk);
        // Fill with NOPs, then load the program while in reset (R10 load port)
        for (int i = 0; i < 64; i++) put(32'h0);
        slot = 0;
        put(iop(6'h08, 1, 0, 16'd3));
        put(iop(6'h08, 2, 0, 16'd4));
        put(iop(6'h08, 3, 0, 16'hFFFB));
        put(32'h0);
        put(rop(4, 1, 2, 6'h20));
        put(rop(5, 1, 2, 6'h22));
        put(rop(6, 1, 3, 6'h24));
        put(rop(7, 2, 3, 6'h25));
        put(rop(8, 3, 1, 6'h2A));
        put(rop(9, 1, 3, 6'h2A));
        put(iop(6'h0A, 10, 3, 16'hFFFC));
        put(iop(6'h0A, 11, 1, 16'd2));
        put(rop(12, 1, 3, 6'h18));
        put(iop(6'h08, 13, 0, 16'h7FFF));
        put(32'h0); put(32'h0);
        put(rop(14, 13, 13, 6'h18));
        put(iop(6'h2B, 1, 0, 16'd4));
        put(iop(6'h2B, 3, 2, 16'd8));
        put(rop(15, 14, 13, 6'h18));
        put(iop(6'h23, 16, 0, 16'd4));
        put(iop(6'h23, 17, 2, 16'd8));
        put(iop(6'h08, 0, 0, 16'd7));
        put(32'h0); put(32'h0);
        put(rop(18, 0, 1, 6'h20));
        put(iop(6'h08, 19, 0, 16'd9));
        put(rop(20, 19, 0, 6'h20));
        put(rop(21, 19, 0, 6'h20));
        put(rop(22, 19, 0, 6'h20));
        put(iop(6'h04, 2, 1, 16'd5));
        put(iop(6'h08, 24, 0, 16'd11));
        put(32'h0); put(32'h0);
        put(iop(6'h08, 23, 0, 16'd1));
        put(32'h0);
        put(iop(6'h04, 16, 1, 16'd4));
        put(iop(6'h08, 25, 0, 16'd21));
        put(32'h0); put(32'h0);
        put(iop(6'h08, 26, 0, 16'd99));
        put(iop(6'h08, 27, 0, 16'd55));
        put(iop(6'h04, 0, 0, 16'hFFFF));

        // Reset state (R1)
        chk("R1 pc after reset", fetch_pc, 32'd0);
        reg_chk("R1 register cleared", 1, 32'd0);
        reg_chk("R1 register cleared", 31, 32'd0);

        rst = 1'b0;
        @(negedge clk);
        chk("R10 pc step", fetch_pc, 32'd4);
        @(negedge clk);
        chk("R10 pc step", fetch_pc, 32'd8);

        repeat (100) @(negedge clk);

        for (int i = 0; i < 28; i++) begin
            dbg_reg_sel = EXP[i][40:36];
            #1;
            checks++;
            if (dbg_reg_val !== EXP[i][35:4]) begin
                errors++;
                $display("FAIL R%0d reg %0d actual=%h expected=%h",
                         EXP[i][3:0], EXP[i][40:36], dbg_reg_val, EXP[i][35:4]);
            end
        end

        // R6 stored words visible in data memory
        dbg_mem_sel = 6'd1; #1;
        chk("R6 store word 1", dbg_mem_val, 32'd3);
        dbg_mem_sel = 6'd3; #1;
        chk("R6 store word 3", dbg_mem_val, 32'hFFFFFFFB);

        // R7 backward branch keeps fetch inside the halt loop
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            checks++;
            if (fetch_pc < 32'd168 || fetch_pc > 32'd180) begin
                errors++;
                $display("FAIL R7 halt loop pc actual=%h expected=168..180", fetch_pc);
            end
        end

        // R1 reset in mid-run
        rst = 1'b1;
        @(negedge clk);
        chk("R1 pc after mid-run reset", fetch_pc, 32'd0);
        reg_chk("R1 register cleared mid-run", 27, 32'd0);
        @(negedge clk);
        chk("R1 pc held in reset", fetch_pc, 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule